// File: doc/BRIEF.md
# Reset Strap Configuration Capture

This block reads boot-strap levels presented on shared address and debug pins and turns them into decoded configuration fields when reset is released. The pin levels pass through a two-stage synchronizer, and the capture takes the last synchronized value present before the reset release is seen. Every strap uses active-low encoding: a pin pulled low selects the non-default option.

There are two capture domains. The system clock divisor, the trace pin assignment and a reserved test bit belong to the power-on domain. They are sampled only when the power-on reset is released, and a system reset alone leaves them unchanged. The boot source and its clock ratio, the channel 0 acknowledge-input mode, the bus arbiter choice and the core timer interrupt disable belong to the system domain. They are sampled again on every system reset release, including the release that follows power-on.

A reserved boot code raises an error flag and falls back to booting from channel 0 at ratio 1/1. Both resets are active-low levels sampled on the clock. A power-on reset also holds the system domain in reset. While a domain is held in reset, its fields show the all-high defaults.

Top module: `strap_capture`

## Requirements
- R1: Boot code bits {b2,b1,b0} = 111, 110 and 101 give bootPci=0 with bootRatio 1, 2 and 3 respectively, and bootCodeErr=0.
- R2: Boot code 011 gives bootPci=1 and bootCodeErr=0.
- R3: Boot codes 100, 010, 001 and 000 give bootCodeErr=1, bootPci=0 and bootRatio=1. Capturing a valid code afterwards clears bootCodeErr.
- R4: ackInputEn is 1 when the acknowledge strap is captured low and 0 when it is captured high.
- R5: The divisor strap {d1,d0} gives sysClkDiv 00→4, 01→3, 10→2, 11→1.
- R6: arbInternal equals the captured arbiter strap (0 = external arbiter, 1 = built-in).
- R7: timerIntDis equals the captured timer strap (0 = interrupts enabled, 1 = disabled).
- R8: traceOnPins is 1 when the trace strap is captured low and 0 when it is high. cfgTestBit equals the captured test strap.
- R9: sysClkDiv, traceOnPins and cfgTestBit are captured only on power-on reset release. A system reset with power-on deasserted leaves them unchanged, even when the straps differ.
- R10: The boot, acknowledge, arbiter and timer fields are captured on every system reset release and on power-on release.
- R11: A strap level held at the pins for at least two clocks before the release is captured. A change made in the final clock before the release is not captured; the previous level is taken instead.
- R12: While a domain is in reset, its fields show the all-high defaults (bootPci=0, bootRatio=1, ackInputEn=0, sysClkDiv=1, arbInternal=1, timerIntDis=1, traceOnPins=0, cfgTestBit=1, bootCodeErr=0). After release, strap changes do not affect the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Power-on reset, active low |
| sysRstN | input | 1 | System reset, active low |
| strapBoot | input | 3 | Boot select strap pins |
| strapAck | input | 1 | Acknowledge-mode strap (low = enable) |
| strapDiv | input | 2 | System clock divisor strap |
| strapArb | input | 1 | Arbiter select strap |
| strapTimer | input | 1 | Timer interrupt disable strap |
| strapTrace | input | 1 | Trace pin assignment strap (low = trace) |
| strapTest | input | 1 | Reserved test strap |
| bootPci | output | 1 | 1 = boot over PCI, 0 = external channel 0 |
| bootRatio | output | 2 | Channel 0 clock ratio denominator (1..3) |
| bootCodeErr | output | 1 | Reserved boot code was captured |
| ackInputEn | output | 1 | Channel 0 acknowledge-input mode enabled |
| sysClkDiv | output | 3 | System clock divisor (1..4) |
| arbInternal | output | 1 | Built-in PCI arbiter selected |
| timerIntDis | output | 1 | Core timer interrupts disabled |
| traceOnPins | output | 1 | Shared pins assigned to trace output |
| cfgTestBit | output | 1 | Captured reserved test strap |

## Verification
The hardest situation to reach from the ports is the window set by the synchronizer at the reset release. To create it, the bench changes the straps exactly one clock before the release and expects the old levels. It then repeats the change two clocks before the release and expects the new levels. The domain split is exercised by changing every strap between a power-on cycle and a later system-only reset. The bench then expects the power-on fields to hold and the system fields to follow the new straps.

// File: rtl/strap_pkg.sv
package strap_pkg;
  localparam int BOOT_LSB  = 0;
  localparam int BOOT_W    = 3;
  localparam int ACK_BIT   = BOOT_LSB + BOOT_W;
  localparam int ARB_BIT   = ACK_BIT + 1;
  localparam int TMR_BIT   = ARB_BIT + 1;
  localparam int SYS_W     = TMR_BIT + 1;
  localparam int DIV_LSB   = 0;
  localparam int DIV_W     = 2;
  localparam int TRACE_BIT = DIV_LSB + DIV_W;
  localparam int TEST_BIT  = TRACE_BIT + 1;
  localparam int POR_W     = TEST_BIT + 1;
  localparam int STRAP_W   = SYS_W + POR_W;

  typedef struct packed {
    logic capPor;
    logic capSys;
    logic clrPor;
    logic clrSys;
  } strapStrobe_t;
endpackage

// File: rtl/strap_ctrl.sv
module strap_ctrl
  import strap_pkg::*;
(
  input  logic         clk,
  input  logic         porRstN,
  input  logic         sysRstN,
  output strapStrobe_t strb
);
  logic porSeen;
  logic sysSeen;
  logic sysLive;

  assign sysLive = porRstN & sysRstN;

  always_ff @(posedge clk) begin
    porSeen <= porRstN;
    sysSeen <= sysLive;
  end

  always_comb begin
    strb.capPor = porRstN & ~porSeen;
    strb.capSys = sysLive & ~sysSeen;
    strb.clrPor = ~porRstN;
    strb.clrSys = ~sysLive;
  end

  // R10: a power-on release with system reset idle also re-arms the system domain
  assert_por_pulls_sys_R10: assert property (@(posedge clk) disable iff (!porRstN)
    (strb.capPor && sysRstN) |-> strb.capSys);

  // R10: the system capture strobe is a single-cycle pulse
  assert_sys_pulse_R10: assert property (@(posedge clk) disable iff (!porRstN)
    strb.capSys |=> !strb.capSys);
endmodule

// File: rtl/strap_datapath.sv
module strap_datapath
  import strap_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  strapStrobe_t       strb,
  input  logic [STRAP_W-1:0] strapIn,
  output logic [SYS_W-1:0]   sysQ,
  output logic [POR_W-1:0]   porQ
);
  localparam logic [SYS_W-1:0] SYS_DEFAULT = '1;
  localparam logic [POR_W-1:0] POR_DEFAULT = '1;

  logic [STRAP_W-1:0] syncQ [SYNC_STAGES];

  always_ff @(posedge clk) syncQ[0] <= strapIn;

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk) syncQ[s] <= syncQ[s-1];
  end

  logic [STRAP_W-1:0] syncOut;
  assign syncOut = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (strb.clrSys)      sysQ <= SYS_DEFAULT;
    else if (strb.capSys) sysQ <= syncOut[SYS_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (strb.clrPor)      porQ <= POR_DEFAULT;
    else if (strb.capPor) porQ <= syncOut[STRAP_W-1:SYS_W];
  end

  // R9: power-on fields hold whenever no power-on capture occurs
  assert_por_hold_R9: assert property (@(posedge clk) disable iff (strb.clrPor)
    !strb.capPor |=> $stable(porQ));

  // R12: system fields hold between captures
  assert_sys_hold_R12: assert property (@(posedge clk) disable iff (strb.clrSys)
    !strb.capSys |=> $stable(sysQ));
endmodule

// File: rtl/strap_capture.sv
module strap_capture
  import strap_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       porRstN,
  input  logic       sysRstN,
  input  logic [2:0] strapBoot,
  input  logic       strapAck,
  input  logic [1:0] strapDiv,
  input  logic       strapArb,
  input  logic       strapTimer,
  input  logic       strapTrace,
  input  logic       strapTest,
  output logic       bootPci,
  output logic [1:0] bootRatio,
  output logic       bootCodeErr,
  output logic       ackInputEn,
  output logic [2:0] sysClkDiv,
  output logic       arbInternal,
  output logic       timerIntDis,
  output logic       traceOnPins,
  output logic       cfgTestBit
);
  strapStrobe_t       strb;
  logic [STRAP_W-1:0] strapIn;
  logic [SYS_W-1:0]   sysQ;
  logic [POR_W-1:0]   porQ;

  assign strapIn = {strapTest, strapTrace, strapDiv,
                    strapTimer, strapArb, strapAck, strapBoot};

  strap_ctrl i_ctrl (
    .clk     (clk),
    .porRstN (porRstN),
    .sysRstN (sysRstN),
    .strb    (strb)
  );

  strap_datapath #(.SYNC_STAGES(SYNC_STAGES)) i_dp (
    .clk     (clk),
    .strb    (strb),
    .strapIn (strapIn),
    .sysQ    (sysQ),
    .porQ    (porQ)
  );

  logic [BOOT_W-1:0] bootCode;
  assign bootCode = sysQ[BOOT_LSB +: BOOT_W];

  always_comb begin
    bootPci     = 1'b0;
    bootRatio   = 2'd1;
    bootCodeErr = 1'b0;
    unique case (bootCode)
      3'b111:  bootRatio = 2'd1;
      3'b110:  bootRatio = 2'd2;
      3'b101:  bootRatio = 2'd3;
      3'b011:  bootPci   = 1'b1;
      default: bootCodeErr = 1'b1;
    endcase
  end

  assign ackInputEn  = ~sysQ[ACK_BIT];
  assign arbInternal = sysQ[ARB_BIT];
  assign timerIntDis = sysQ[TMR_BIT];
  assign sysClkDiv   = 3'd4 - {1'b0, porQ[DIV_LSB +: DIV_W]};
  assign traceOnPins = ~porQ[TRACE_BIT];
  assign cfgTestBit  = porQ[TEST_BIT];

  // R3: a reserved code always falls back to channel 0 at ratio 1/1
  assert_err_fallback_R3: assert property (@(posedge clk) disable iff (!porRstN)
    bootCodeErr |-> (!bootPci && bootRatio == 2'd1));

  // R5: divisor stays within 1..4
  assert_div_range_R5: assert property (@(posedge clk) disable iff (!porRstN)
    (sysClkDiv >= 3'd1 && sysClkDiv <= 3'd4));
endmodule

// File: tb/test_strap_capture.sv
module test_strap_capture;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       porRstN = 1'b0;
  logic       sysRstN = 1'b0;
  logic [2:0] strapBoot = 3'b111;
  logic       strapAck = 1'b1;
  logic [1:0] strapDiv = 2'b11;
  logic       strapArb = 1'b1;
  logic       strapTimer = 1'b1;
  logic       strapTrace = 1'b1;
  logic       strapTest = 1'b1;
  logic       bootPci, bootCodeErr, ackInputEn, arbInternal;
  logic       timerIntDis, traceOnPins, cfgTestBit;
  logic [1:0] bootRatio;
  logic [2:0] sysClkDiv;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  strap_capture i_strap_capture (
    .clk(clk), .porRstN(porRstN), .sysRstN(sysRstN),
    .strapBoot(strapBoot), .strapAck(strapAck), .strapDiv(strapDiv),
    .strapArb(strapArb), .strapTimer(strapTimer), .strapTrace(strapTrace),
    .strapTest(strapTest),
    .bootPci(bootPci), .bootRatio(bootRatio), .bootCodeErr(bootCodeErr),
    .ackInputEn(ackInputEn), .sysClkDiv(sysClkDiv), .arbInternal(arbInternal),
    .timerIntDis(timerIntDis), .traceOnPins(traceOnPins), .cfgTestBit(cfgTestBit)
  );

  task automatic check(string req, int act, int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("[TB] FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setStraps(logic [2:0] b, logic a, logic [1:0] d,
                           logic ar, logic t, logic tr, logic ts);
    strapBoot = b; strapAck = a; strapDiv = d; strapArb = ar;
    strapTimer = t; strapTrace = tr; strapTest = ts;
  endtask

  task automatic porCycle();
    porRstN = 1'b0; sysRstN = 1'b1;
    cyc(4);
    porRstN = 1'b1;
    cyc(2);
  endtask

  task automatic sysCycle();
    sysRstN = 1'b0;
    cyc(4);
    sysRstN = 1'b1;
    cyc(2);
  endtask

  task automatic testResetDefaults();
    setStraps(3'b000, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
    porRstN = 1'b0; sysRstN = 1'b0;
    cyc(4);
    check("R12 bootPci", bootPci, 0);
    check("R12 bootRatio", bootRatio, 1);
    check("R12 bootCodeErr", bootCodeErr, 0);
    check("R12 ackInputEn", ackInputEn, 0);
    check("R12 sysClkDiv", sysClkDiv, 1);
    check("R12 arbInternal", arbInternal, 1);
    check("R12 timerIntDis", timerIntDis, 1);
    check("R12 traceOnPins", traceOnPins, 0);
    check("R12 cfgTestBit", cfgTestBit, 1);
  endtask

  task automatic testPowerOnLowStraps();
    setStraps(3'b110, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
    porCycle();
    check("R1 ratio 1/2", bootRatio, 2);
    check("R4 ack enabled", ackInputEn, 1);
    check("R5 div LL", sysClkDiv, 4);
    check("R6 external arbiter", arbInternal, 0);
    check("R7 timer enabled", timerIntDis, 0);
    check("R8 trace on pins", traceOnPins, 1);
    check("R8 test bit low", cfgTestBit, 0);
  endtask

  task automatic testBootCodes();
    for (int c = 0; c < 8; c++) begin
      int expPci, expRatio, expErr;
      strapBoot = 3'(c);
      sysCycle();
      expPci = (c == 3) ? 1 : 0;
      expErr = (c == 7 || c == 6 || c == 5 || c == 3) ? 0 : 1;
      expRatio = (c == 6) ? 2 : (c == 5) ? 3 : 1;
      check((c == 3) ? "R2 pci" : (expErr != 0) ? "R3 reserved pci" : "R1 pci", bootPci, expPci);
      check((expErr != 0) ? "R3 reserved ratio" : "R1 ratio", bootRatio, expRatio);
      check((expErr != 0) ? "R3 err set" : "R3 err clear", bootCodeErr, expErr);
    end
  endtask

  task automatic testSysResetKeepsPorFields();
    setStraps(3'b101, 1'b1, 2'b10, 1'b1, 1'b1, 1'b0, 1'b0);
    porCycle();
    check("R5 div HL", sysClkDiv, 2);
    setStraps(3'b011, 1'b0, 2'b01, 1'b0, 1'b0, 1'b1, 1'b1);
    sysCycle();
    check("R9 div held", sysClkDiv, 2);
    check("R9 trace held", traceOnPins, 1);
    check("R9 test held", cfgTestBit, 0);
    check("R10 boot recaptured", bootPci, 1);
    check("R10 ack recaptured", ackInputEn, 1);
    check("R10 arb recaptured", arbInternal, 0);
    check("R10 timer recaptured", timerIntDis, 0);
    porCycle();
    check("R9 div on power-on", sysClkDiv, 3);
    check("R8 trace off", traceOnPins, 0);
    check("R8 test bit high", cfgTestBit, 1);
  endtask

  task automatic testHoldAfterRelease();
    setStraps(3'b111, 1'b1, 2'b11, 1'b1, 1'b1, 1'b1, 1'b1);
    porCycle();
    setStraps(3'b000, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
    cyc(5);
    check("R12 boot ignores pins", bootCodeErr, 0);
    check("R12 div ignores pins", sysClkDiv, 1);
    check("R12 ack ignores pins", ackInputEn, 0);
    check("R12 trace ignores pins", traceOnPins, 0);
  endtask

  task automatic testSyncWindow();
    setStraps(3'b111, 1'b1, 2'b11, 1'b1, 1'b1, 1'b1, 1'b1);
    porRstN = 1'b0; sysRstN = 1'b1;
    cyc(4);
    setStraps(3'b011, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
    cyc(1);
    porRstN = 1'b1;
    cyc(3);
    check("R11 late boot change missed", bootPci, 0);
    check("R11 late div change missed", sysClkDiv, 1);
    porRstN = 1'b0;
    setStraps(3'b111, 1'b1, 2'b11, 1'b1, 1'b1, 1'b1, 1'b1);
    cyc(4);
    setStraps(3'b011, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
    cyc(2);
    porRstN = 1'b1;
    cyc(3);
    check("R11 two-cycle boot captured", bootPci, 1);
    check("R11 two-cycle div captured", sysClkDiv, 4);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("[TB] FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    cyc(1);
    testResetDefaults();
    testPowerOnLowStraps();
    testBootCodes();
    testSysResetKeepsPorFields();
    testHoldAfterRelease();
    testSyncWindow();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule